// File: doc/BRIEF.md
# Per-CPU interrupt priority arbiter

This block delivers interrupts to one processor. Each of `N` sources presents an active level, a 4-bit priority and an 8-bit vector. When a source becomes active it is entered into a *pending* set. When it is acknowledged it moves into an *in-service* set. The block finds the highest-priority member of each set and drives a single interrupt line to the processor.

The interrupt line is gated by two things: a per-processor task-priority threshold, and the priority of the interrupt currently being serviced. A source whose priority is too low for the threshold is still kept pending. It can therefore fire later, once software lowers the threshold.

Software reaches the block through a small word-addressed register port with four registers:

| Offset | Access | Function |
|--------|--------|----------|
| 0x00 | read/write | Task-priority threshold |
| 0x10 | read | Acknowledge |
| 0x20 | write | End of service |
| 0x30 | read/write | Spurious vector |

Read data appears one cycle after the read strobe, qualified by `bus_rvalid`.

Top module: `irq_cpu_arbiter`

## Requirements
- R1: After reset the threshold reads 15 at offset 0x00 and the interrupt line is low. While the threshold is 15 the line never rises.
- R2: A source whose active input rises is entered into the pending set even when its priority is not above the threshold. A later threshold write below its priority asserts the line.
- R3: The line is high exactly when the pending set is non-empty and two conditions hold. Its top priority must be strictly greater than the threshold. It must also be strictly greater than the top in-service priority, where an empty in-service set counts as below every priority.
- R4: The top of a set is the member with the greatest priority. Among equal priorities the lowest-numbered source wins.
- R5: A read of offset 0x10 with nothing pending returns the spurious vector, and the sets are unchanged.
- R6: A read of offset 0x10 whose top pending source is still active and above the threshold has three effects. It returns that source's vector in bits 7:0 with zeros above. It removes the source from the pending set. It adds the source to the in-service set.
- R7: A read of offset 0x10 whose top pending source is inactive or not above the threshold returns the spurious vector and changes neither set.
- R8: A write of any value to offset 0x20 removes the top in-service member, and the line follows R3 afterwards. With nothing in service the write has no effect.
- R9: A source whose active input falls is removed from the pending set, and the line follows R3 afterwards.
- R10: An access whose address bits 3:0 are not zero changes no register, and a read of it returns all ones. A read of any unmapped or write-only offset also returns all ones. Every read strobe yields `bus_rvalid` on the next cycle only.
- R11: A write to offset 0x00 keeps bits 3:0 of the data as the new threshold. The threshold reads back zero-extended.
- R12: The spurious vector resets to 0xFF. A write to offset 0x30 keeps bits 7:0 of the data, and the value reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_active | input | N | Active level of each source |
| src_prio | input | 4*N | Priority of source i in bits 4i+3:4i |
| src_vec | input | 8*N | Vector of source i in bits 8i+7:8i |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledge reads have side effects) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after each read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A pending or in-service bit that is stuck or lost shows up in two places. The interrupt line changes at the first threshold write, source edge or end-of-service write that should have moved it. The next acknowledge returns the wrong vector or the spurious vector. A wrong tie-break or an off-by-one priority comparison is visible one cycle after the access that exposes it.

The bench therefore compares the line after every cycle, and every read result, against a reference model of the two sets. Random source toggling is mixed with random threshold, acknowledge and end-of-service traffic.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTPR = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SPUR = 8'h30;

  localparam logic [PRIO_W-1:0] CTPR_RESET = '1;
  localparam logic [VEC_W-1:0]  SPUR_RESET = '1;

  typedef enum logic [1:0] {
    RSEL_ONES,
    RSEL_CTPR,
    RSEL_ACK,
    RSEL_SPUR
  } rsel_e;
endpackage

// File: rtl/irq_arb_rst_sync.sv
`timescale 1ns/1ps
module irq_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_prio_find.sv
`timescale 1ns/1ps
module irq_prio_find
  import irq_arb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]        member,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                found,
  output logic [IW-1:0]       idx,
  output logic [PRIO_W-1:0]   pri
);
  // Strictly-greater replacement: on equal priority the earlier index stays.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pri   = '0;
    for (int i = 0; i < N; i++) begin
      if (member[i] && (!found || (prio[i*PRIO_W +: PRIO_W] > pri))) begin
        found = 1'b1;
        idx   = IW'(i);
        pri   = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_arb_regif.sv
`timescale 1ns/1ps
module irq_arb_regif
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ack_ok,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic [PRIO_W-1:0] ctpr,
  output logic              ack_req,
  output logic              eoi_req,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  logic              aligned;
  logic              ctpr_en;
  logic              spur_en;
  logic              rdata_en;
  logic [PRIO_W-1:0] ctpr_q, ctpr_d;
  logic [VEC_W-1:0]  spur_q, spur_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  rsel_e             rsel;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:VEC_W];

  // Address decode; anything off a 16-byte boundary is dropped.
  always_comb begin
    aligned = (bus_addr[3:0] == 4'h0);
    ctpr_en = bus_wr && aligned && (bus_addr == OFS_CTPR);
    spur_en = bus_wr && aligned && (bus_addr == OFS_SPUR);
    eoi_req = bus_wr && aligned && (bus_addr == OFS_EOI);
    ack_req = bus_rd && aligned && (bus_addr == OFS_ACK);
    rsel    = RSEL_ONES;
    if (aligned) begin
      case (bus_addr)
        OFS_CTPR: rsel = RSEL_CTPR;
        OFS_ACK:  rsel = RSEL_ACK;
        OFS_SPUR: rsel = RSEL_SPUR;
        default:  rsel = RSEL_ONES;
      endcase
    end
  end

  // Next-state values.
  always_comb begin
    ctpr_d   = bus_wdata[PRIO_W-1:0];
    spur_d   = bus_wdata[VEC_W-1:0];
    rdata_en = bus_rd;
    rvalid_d = bus_rd;
    case (rsel)
      RSEL_CTPR: rdata_d = DATA_W'(ctpr_q);
      RSEL_ACK:  rdata_d = ack_ok ? DATA_W'(ack_vec) : DATA_W'(spur_q);
      RSEL_SPUR: rdata_d = DATA_W'(spur_q);
      default:   rdata_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctpr_q   <= CTPR_RESET;
      spur_q   <= SPUR_RESET;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (ctpr_en)  ctpr_q  <= ctpr_d;
      if (spur_en)  spur_q  <= spur_d;
      if (rdata_en) rdata_q <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign ctpr       = ctpr_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/irq_cpu_arbiter.sv
`timescale 1ns/1ps
module irq_cpu_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        src_active,
  input  logic [N*PRIO_W-1:0] src_prio,
  input  logic [N*VEC_W-1:0]  src_vec,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                irq_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic              rst_sync_n;
  logic [N-1:0]      act_q, act_d;
  logic [N-1:0]      raised_q, raised_d;
  logic [N-1:0]      serv_q, serv_d;
  logic [N-1:0]      rises, falls;
  logic              set_en;
  logic              r_found, s_found;
  logic [IW-1:0]     r_idx, s_idx;
  logic [PRIO_W-1:0] r_pri, s_pri;
  logic [PRIO_W-1:0] ctpr_val;
  logic              ack_req, eoi_req, ack_ok;
  logic [VEC_W-1:0]  ack_vec;

  irq_arb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_prio_find #(.N(N), .IW(IW)) u_find_raised (
    .member (raised_q),
    .prio   (src_prio),
    .found  (r_found),
    .idx    (r_idx),
    .pri    (r_pri)
  );

  irq_prio_find #(.N(N), .IW(IW)) u_find_serv (
    .member (serv_q),
    .prio   (src_prio),
    .found  (s_found),
    .idx    (s_idx),
    .pri    (s_pri)
  );

  irq_arb_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ack_ok     (ack_ok),
    .ack_vec    (ack_vec),
    .ctpr       (ctpr_val),
    .ack_req    (ack_req),
    .eoi_req    (eoi_req),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  // Acknowledge qualification against the current source level and threshold.
  assign ack_vec = src_vec[r_idx*VEC_W +: VEC_W];
  assign ack_ok  = ack_req && r_found && src_active[r_idx] && (r_pri > ctpr_val);

  assign rises = src_active & ~act_q;
  assign falls = ~src_active & act_q;

  always_comb begin
    act_d    = src_active;
    raised_d = (raised_q | rises) & ~falls;
    serv_d   = serv_q;
    if (ack_ok) begin
      raised_d[r_idx] = 1'b0;
      serv_d[r_idx]   = 1'b1;
    end
    if (eoi_req && s_found) begin
      serv_d[s_idx] = 1'b0;
    end
    set_en = (|rises) || (|falls) || ack_ok || (eoi_req && s_found);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q    <= '0;
      raised_q <= '0;
      serv_q   <= '0;
    end else begin
      act_q <= act_d;
      if (set_en) begin
        raised_q <= raised_d;
        serv_q   <= serv_d;
      end
    end
  end

  // Line gated by the threshold and by the top in-service priority.
  assign irq_o = r_found && (r_pri > ctpr_val) && (!s_found || (r_pri > s_pri));
endmodule

// File: rtl/irq_arb_checker.sv
`timescale 1ns/1ps
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PRIO_W-1:0] wdata_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_o,
  input logic [PRIO_W-1:0] ctpr,
  input logic [N-1:0]      serv_q
);
  p_full_threshold_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctpr == CTPR_RESET) |-> !irq_o);

  p_threshold_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_CTPR)) |=> (ctpr == $past(wdata_lo)));

  p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && (bus_addr == OFS_EOI) && (serv_q == '0)) |=> (serv_q == '0));

  p_misaligned_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr[3:0] != 4'h0)) |=> (bus_rdata == '1));

  p_misaligned_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[3:0] != 4'h0)) |=> $stable(ctpr));

  p_rvalid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind irq_cpu_arbiter irq_arb_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .wdata_lo   (bus_wdata[3:0]),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq_o      (irq_o),
  .ctpr       (ctpr_val),
  .serv_q     (serv_q)
);

// File: tb/sim_irq_cpu_arbiter.sv
`timescale 1ns/1ps
module sim_irq_cpu_arbiter;
  localparam int N = 16;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src_active;
  logic [N*4-1:0] src_prio;
  logic [N*8-1:0] src_vec;
  logic          bus_wr, bus_rd;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          irq_o;

  logic [3:0]    prio_arr [N];
  int            n_checks = 0;
  int            n_err    = 0;
  bit            done     = 0;

  // Reference model state
  logic [N-1:0]  m_act, m_raised, m_serv;
  logic [3:0]    m_ctpr;
  logic [7:0]    m_spur;
  logic [N-1:0]  cur_act;

  irq_cpu_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_active(src_active), .src_prio(src_prio),
    .src_vec(src_vec), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      src_prio[i*4 +: 4] = prio_arr[i];
      src_vec[i*8 +: 8]  = 8'h40 + 8'(i);
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Top member: greatest priority, lowest index on ties, -1 when empty.
  function automatic void find_top(input logic [N-1:0] s, output bit f,
                                   output int idx, output int p);
    f = 0; idx = -1; p = -1;
    for (int i = 0; i < N; i++) begin
      if (s[i] && (int'(prio_arr[i]) > p)) begin
        f = 1; idx = i; p = int'(prio_arr[i]);
      end
    end
  endfunction

  function automatic bit model_irq();
    bit rf, sf; int ri, rp, si, sp;
    find_top(m_raised, rf, ri, rp);
    find_top(m_serv, sf, si, sp);
    return rf && (rp > int'(m_ctpr)) && (rp > sp);
  endfunction

  task automatic step(input logic [N-1:0] act, input bit wr, input bit rd,
                      input logic [7:0] addr, input logic [31:0] wd, input string tag);
    bit rf, sf, aligned, ackok;
    int ri, rp, si, sp;
    logic [31:0] exp_rd;
    logic [N-1:0] rises, falls;
    src_active = act; bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
    rises = act & ~m_act;
    falls = ~act & m_act;
    find_top(m_raised, rf, ri, rp);
    find_top(m_serv, sf, si, sp);
    aligned = (addr[3:0] == 4'h0);
    ackok = rd && aligned && (addr == 8'h10) && rf && act[ri] && (rp > int'(m_ctpr));
    exp_rd = '1;
    if (aligned) begin
      case (addr)
        8'h00: exp_rd = {28'h0, m_ctpr};
        8'h10: exp_rd = ackok ? {24'h0, 8'h40 + 8'(ri)} : {24'h0, m_spur};
        8'h30: exp_rd = {24'h0, m_spur};
        default: exp_rd = '1;
      endcase
    end
    m_raised = (m_raised | rises) & ~falls;
    if (ackok) begin
      m_raised[ri] = 1'b0;
      m_serv[ri]   = 1'b1;
    end
    if (wr && aligned && (addr == 8'h20) && sf) m_serv[si] = 1'b0;
    if (wr && aligned && (addr == 8'h00)) m_ctpr = wd[3:0];
    if (wr && aligned && (addr == 8'h30)) m_spur = wd[7:0];
    m_act = act;
    @(negedge clk);
    check(irq_o === model_irq(), {tag, " irq"}, 32'(irq_o), 32'(model_irq()));
    check(bus_rvalid === rd, "R10 rvalid", 32'(bus_rvalid), 32'(rd));
    if (rd) check(bus_rdata === exp_rd, {tag, " rdata"}, bus_rdata, exp_rd);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(cur_act, 1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(cur_act, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd_reg(input logic [7:0] a, input string tag);
    step(cur_act, 1'b0, 1'b1, a, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) prio_arr[i] = 4'((i % 7) + 1);
    prio_arr[0] = 4'd5; prio_arr[1] = 4'd9; prio_arr[2] = 4'd9; prio_arr[3] = 4'd3;
    rst_n = 1'b0; src_active = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    m_act = '0; m_raised = '0; m_serv = '0; m_ctpr = 4'hF; m_spur = 8'hFF; cur_act = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(irq_o === 1'b0, "R1 irq after reset", 32'(irq_o), 32'h0);
    rd_reg(8'h00, "R1");
    rd_reg(8'h30, "R12");
    rd_reg(8'h10, "R5");

    // R2 blocked source stays pending, fires when threshold drops
    cur_act[1] = 1'b1; idle("R2");
    wr_reg(8'h00, 32'h0, "R2");
    // R3 strict comparison against threshold
    wr_reg(8'h00, 32'h9, "R3");
    wr_reg(8'h00, 32'h8, "R3");
    // R4 tie: source 1 beats source 2
    cur_act[2] = 1'b1; idle("R4");
    rd_reg(8'h10, "R4");
    idle("R6");
    // R8 end of service re-exposes source 2
    wr_reg(8'h20, 32'h0, "R8");
    rd_reg(8'h10, "R6");
    wr_reg(8'h20, 32'h0, "R8");
    wr_reg(8'h20, 32'h0, "R8");
    idle("R8");
    // R9 falling source withdrawn
    cur_act[1] = 1'b0; cur_act[2] = 1'b0; idle("R9");
    wr_reg(8'h00, 32'h0, "R9");
    cur_act[3] = 1'b1; idle("R9");
    cur_act[3] = 1'b0; idle("R9");
    // R7 acknowledge below threshold gives spurious, source stays pending
    cur_act[0] = 1'b1; wr_reg(8'h00, 32'hF, "R7");
    rd_reg(8'h10, "R7");
    wr_reg(8'h00, 32'h0, "R7");
    rd_reg(8'h10, "R6");
    wr_reg(8'h20, 32'h0, "R8");
    // R10 misaligned and unmapped
    wr_reg(8'h04, 32'h7, "R10");
    rd_reg(8'h00, "R10");
    rd_reg(8'h14, "R10");
    rd_reg(8'h20, "R10");
    rd_reg(8'h50, "R10");
    // R11 threshold width
    wr_reg(8'h00, 32'hFFFF_FFF3, "R11");
    rd_reg(8'h00, "R11");
    // R12 spurious vector
    wr_reg(8'h30, 32'h0000_01A5, "R12");
    rd_reg(8'h30, "R12");
    cur_act[0] = 1'b0; idle("R9");
    rd_reg(8'h10, "R5");

    // Constrained random traffic
    for (int i = 0; i < N; i++) prio_arr[i] = 4'($urandom_range(0, 15));
    for (int it = 0; it < 4000; it++) begin
      int r;
      logic [N-1:0] act;
      r = $urandom_range(0, 99);
      act = cur_act;
      if ($urandom_range(0, 2) == 0) act[$urandom_range(0, N-1)] ^= 1'b1;
      cur_act = act;
      if (r < 25)      rd_reg(8'h10, "R6");
      else if (r < 40) wr_reg(8'h20, 32'($urandom), "R8");
      else if (r < 50) wr_reg(8'h00, 32'($urandom_range(0, 15)), "R3");
      else if (r < 55) rd_reg(8'h00, "R11");
      else if (r < 58) wr_reg({4'($urandom_range(0, 3)), 4'($urandom_range(1, 15))},
                              32'($urandom), "R10");
      else if (r < 61) rd_reg({4'($urandom_range(0, 15)), 4'($urandom_range(1, 15))}, "R10");
      else if (r < 62) wr_reg(8'h30, 32'($urandom), "R12");
      else             idle("R3");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule